// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver/Transmitter

This block is a full-duplex asynchronous serial port. The transmit half and the receive half each run from their own clock, and each clock runs at sixteen times the bit rate. Static configuration inputs set the character format. The character length can be five to eight bits. A parity bit is optional and can be even or odd. The frame ends with one or two stop bits, or one and a half stop bits for five-bit characters. The same format inputs serve both directions.

To transmit, the host places a character on the data input and raises a load strobe. The character goes into a holding buffer and then passes to a shift register, which sends a low start bit, the data bits least significant first, the optional parity bit and the stop bits. Two empty flags let the host keep the line busy back to back.

The receiver hunts for a falling edge on the line. It confirms the start bit at its centre, then samples every later bit at its centre. When the character is complete, it moves the character into an output buffer together with its error flags. The host acknowledges the character with a flag-reset input. Bit-rate generation and modem handshake lines are not part of this block.

Top module: `duplex_uart`

## Requirements
- R1: `len_sel` sets the character length as {bit1,bit0}: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. The data bits are sent least significant first, straight after the start bit.
- R2: With `par_off` low, one parity bit follows the data. It makes the count of ones over data plus parity even when `even_par` is 1 and odd when `even_par` is 0. With `par_off` high, no parity bit is sent or checked.
- R3: With `two_stop` low the frame has one stop bit (16 ticks). With it high the frame has two stop bits (32 ticks), except for 5-bit characters, which get 1.5 stop bits (24 ticks). `tx_reg_empty` rises on the edge that ends the last stop tick.
- R4: A rising edge of `tx_load` captures `tx_data`, and `tx_buf_empty` reads 0 after that edge. If the shift register is idle, the next edge moves the character into it, so `tx_buf_empty` returns to 1 and `tx_reg_empty` falls. Holding `tx_load` high does not send the character again.
- R5: `tx_ser` is high when idle. A frame begins with a low start bit on the same edge as the handoff, and every start, data and parity bit lasts 16 ticks.
- R6: If a character is loaded while another frame is shifting, it is handed off on the edge that ends the last stop tick. The line then goes straight into the next start bit, and `tx_reg_empty` stays low.
- R7: After reset, `tx_ser`, `tx_buf_empty` and `tx_reg_empty` are 1. `rx_ready`, `rx_overrun`, `rx_frame_err`, `rx_parity_err` and `rx_data` are 0.
- R8: When a whole character has been received, it goes to `rx_data` and `rx_ready` is set. A character shorter than 8 bits is right-justified, and the unused upper bits read 0.
- R9: On each transfer, `rx_overrun` is set if `rx_ready` was still set from the previous character and was not being reset on that same edge. Otherwise `rx_overrun` is cleared.
- R10: On each transfer, `rx_frame_err` is set if the first stop bit sampled low, and `rx_parity_err` is set if parity is enabled and the received parity bit does not match.
- R11: A low level on `rx_ser` is accepted as a start bit only if the line is still low eight ticks later, at the bit centre. Otherwise it is dropped and hunting resumes.
- R12: `rx_flag_clr` clears `rx_ready`. If it falls on the same edge as a transfer, the transfer wins: `rx_ready` ends set and `rx_overrun` ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock, 16x bit rate |
| rx_clk | input | 1 | Receive clock, 16x bit rate |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| len_sel | input | 2 | Character length select |
| par_off | input | 1 | High disables parity |
| even_par | input | 1 | 1 for even parity, 0 for odd |
| two_stop | input | 1 | Stop-bit count select |
| tx_data | input | 8 | Character to transmit |
| tx_load | input | 1 | Buffer load strobe, acts on its rising edge |
| tx_buf_empty | output | 1 | Transmit holding buffer is empty |
| tx_reg_empty | output | 1 | Transmit shift register is idle |
| tx_ser | output | 1 | Serial output line |
| rx_ser | input | 1 | Serial input line |
| rx_flag_clr | input | 1 | Clears the data-received flag |
| rx_data | output | 8 | Received character, right-justified |
| rx_ready | output | 1 | Data-received flag |
| rx_overrun | output | 1 | Overrun flag |
| rx_frame_err | output | 1 | Framing error flag |
| rx_parity_err | output | 1 | Parity error flag |

## Verification
The case that needs the most care is a character transfer and a host flag reset landing on the same receive edge. The bench first leaves `rx_ready` set from an earlier character. It then drives a frame tick by tick from the start bit, and pulses `rx_flag_clr` for exactly the edge on which the first stop bit is sampled. It expects `rx_ready` set and `rx_overrun` clear. A second same-edge case on the transmit side loads a new character during a frame and checks that the handoff happens on the very edge the last stop tick ends, with no idle tick on the line.

// File: rtl/duplex_uart_pkg.sv
package duplex_uart_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_t;

  // {bit1,bit0}: 00 -> 5, 01 -> 6, 10 -> 7, 11 -> 8 data bits
  function automatic logic [3:0] char_bits(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

  // stop length counted in half bits
  function automatic logic [2:0] stop_halves(input logic two, input logic [1:0] sel);
    if (!two)
      return 3'd2;
    else if (sel == 2'b00)
      return 3'd3;
    else
      return 3'd4;
  endfunction

endpackage

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import duplex_uart_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    len_sel,
  input  logic          par_off,
  input  logic          even_par,
  input  logic          two_stop,
  input  logic [DW-1:0] din,
  input  logic          load,
  output logic          buf_empty,
  output logic          reg_empty,
  output logic          ser
);

  localparam int CW = $clog2(2 * OSR);

  logic          ld_q;
  logic [DW-1:0] hold;
  logic [DW-1:0] sh;
  phase_t        ph;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [3:0]    len_q;
  logic          par_q;
  logic          pbit_q;
  logic [2:0]    halves_q;
  logic [CW-1:0] lim;
  logic          bit_end;
  logic          do_load;
  logic          load_rise;
  logic [DW-1:0] len_mask;

  always_comb begin
    len_mask = '0;
    for (int i = 0; i < DW; i++)
      if (i < int'(char_bits(len_sel))) len_mask[i] = 1'b1;
  end

  always_comb begin
    if (ph == PH_STOP)
      lim = CW'(int'(halves_q) * (OSR / 2));
    else
      lim = CW'(OSR);
  end

  assign bit_end   = (cnt == lim - CW'(1));
  assign load_rise = load & ~ld_q;
  assign do_load   = !buf_empty && ((ph == PH_IDLE) || (ph == PH_STOP && bit_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_q      <= 1'b0;
      hold      <= '0;
      sh        <= '0;
      ph        <= PH_IDLE;
      cnt       <= '0;
      idx       <= '0;
      len_q     <= 4'd8;
      par_q     <= 1'b0;
      pbit_q    <= 1'b0;
      halves_q  <= 3'd2;
      buf_empty <= 1'b1;
      reg_empty <= 1'b1;
      ser       <= 1'b1;
    end else begin
      ld_q <= load;
      if (do_load) begin
        sh        <= hold;
        len_q     <= char_bits(len_sel);
        par_q     <= ~par_off;
        pbit_q    <= even_par ? ^(hold & len_mask) : ~^(hold & len_mask);
        halves_q  <= stop_halves(two_stop, len_sel);
        ser       <= 1'b0;
        ph        <= PH_START;
        cnt       <= '0;
        idx       <= '0;
        buf_empty <= 1'b1;
        reg_empty <= 1'b0;
      end else if (ph != PH_IDLE) begin
        cnt <= cnt + CW'(1);
        if (bit_end) begin
          cnt <= '0;
          case (ph)
            PH_START: begin
              ser <= sh[0];
              ph  <= PH_DATA;
            end
            PH_DATA: begin
              if (idx == len_q - 4'd1) begin
                if (par_q) begin
                  ser <= pbit_q;
                  ph  <= PH_PAR;
                end else begin
                  ser <= 1'b1;
                  ph  <= PH_STOP;
                end
              end else begin
                idx <= idx + 4'd1;
                sh  <= sh >> 1;
                ser <= sh[1];
              end
            end
            PH_PAR: begin
              ser <= 1'b1;
              ph  <= PH_STOP;
            end
            default: begin
              ph        <= PH_IDLE;
              reg_empty <= 1'b1;
            end
          endcase
        end
      end
      // a new strobe edge refills the buffer after any handoff on this edge
      if (load_rise) begin
        hold      <= din;
        buf_empty <= 1'b0;
      end
    end
  end

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
    reg_empty |-> ser) else $error("idle line not high"); // R5

  AST_HANDOFF_NEXT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!buf_empty && reg_empty) |=> (buf_empty && !reg_empty)) else $error("late handoff"); // R4

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(reg_empty) |-> !ser) else $error("frame without start bit"); // R5

endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import duplex_uart_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    len_sel,
  input  logic          par_off,
  input  logic          even_par,
  input  logic          ser_in,
  input  logic          flag_clr,
  output logic [DW-1:0] dout,
  output logic          ready,
  output logic          overrun,
  output logic          frame_err,
  output logic          parity_err
);

  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int IW   = $clog2(DW);

  logic          s1, s2;
  phase_t        ph;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [3:0]    len_q;
  logic [3:0]    buf_len;
  logic          par_q;
  logic          even_q;
  logic          pbad;
  logic [DW-1:0] sh;
  logic          full_bit;
  logic          xfer;

  assign full_bit = (cnt == CW'(OSR - 1));
  assign xfer     = (ph == PH_STOP) && full_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1         <= 1'b1;
      s2         <= 1'b1;
      ph         <= PH_IDLE;
      cnt        <= '0;
      idx        <= '0;
      len_q      <= 4'd8;
      buf_len    <= 4'd8;
      par_q      <= 1'b0;
      even_q     <= 1'b0;
      pbad       <= 1'b0;
      sh         <= '0;
      dout       <= '0;
      ready      <= 1'b0;
      overrun    <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      s1 <= ser_in;
      s2 <= s1;
      case (ph)
        PH_IDLE: begin
          if (!s2) begin
            ph     <= PH_START;
            cnt    <= '0;
            idx    <= '0;
            sh     <= '0;
            pbad   <= 1'b0;
            len_q  <= char_bits(len_sel);
            par_q  <= ~par_off;
            even_q <= even_par;
          end
        end
        PH_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            ph  <= s2 ? PH_IDLE : PH_DATA;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_DATA: begin
          if (full_bit) begin
            cnt             <= '0;
            sh[idx[IW-1:0]] <= s2;
            if (idx == len_q - 4'd1)
              ph <= par_q ? PH_PAR : PH_STOP;
            else
              idx <= idx + 4'd1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_PAR: begin
          if (full_bit) begin
            cnt  <= '0;
            pbad <= (s2 != (even_q ? ^sh : ~^sh));
            ph   <= PH_STOP;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          if (full_bit) begin
            cnt        <= '0;
            ph         <= PH_IDLE;
            dout       <= sh;
            buf_len    <= len_q;
            frame_err  <= ~s2;
            parity_err <= par_q & pbad;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      endcase

      if (xfer) begin
        ready   <= 1'b1;
        overrun <= ready & ~flag_clr;
      end else if (flag_clr) begin
        ready <= 1'b0;
      end
    end
  end

  AST_FRESH_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> !overrun) else $error("overrun on first character"); // R9

  AST_RJUST_ZERO: assert property (@(posedge clk) disable iff (rst)
    ready |-> ((dout >> buf_len) == '0)) else $error("upper bits not zero"); // R8

  AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_START && cnt == CW'(HALF - 1) && s2) |=> (ph == PH_IDLE)) else $error("glitch accepted"); // R11

endmodule

// File: rtl/duplex_uart.sv
module duplex_uart #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          tx_clk,
  input  logic          rx_clk,
  input  logic          rst,
  input  logic [1:0]    len_sel,
  input  logic          par_off,
  input  logic          even_par,
  input  logic          two_stop,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_load,
  output logic          tx_buf_empty,
  output logic          tx_reg_empty,
  output logic          tx_ser,
  input  logic          rx_ser,
  input  logic          rx_flag_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          rx_overrun,
  output logic          rx_frame_err,
  output logic          rx_parity_err
);

  uart_tx_path #(.OSR(OSR), .DW(DW)) u_tx (
    .clk       (tx_clk),
    .rst       (rst),
    .len_sel   (len_sel),
    .par_off   (par_off),
    .even_par  (even_par),
    .two_stop  (two_stop),
    .din       (tx_data),
    .load      (tx_load),
    .buf_empty (tx_buf_empty),
    .reg_empty (tx_reg_empty),
    .ser       (tx_ser)
  );

  uart_rx_path #(.OSR(OSR), .DW(DW)) u_rx (
    .clk        (rx_clk),
    .rst        (rst),
    .len_sel    (len_sel),
    .par_off    (par_off),
    .even_par   (even_par),
    .ser_in     (rx_ser),
    .flag_clr   (rx_flag_clr),
    .dout       (rx_data),
    .ready      (rx_ready),
    .overrun    (rx_overrun),
    .frame_err  (rx_frame_err),
    .parity_err (rx_parity_err)
  );

endmodule

// File: tb/duplex_uart_tb.sv
module duplex_uart_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] len_sel = 2'b11;
  logic       par_off = 1'b1;
  logic       even_par = 1'b0;
  logic       two_stop = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_load = 1'b0;
  logic       tx_buf_empty, tx_reg_empty, tx_ser;
  logic       rx_flag_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, rx_overrun, rx_frame_err, rx_parity_err;
  logic       use_loop = 1'b1;
  logic       drv = 1'b1;
  logic       rx_line;
  int         n_run = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  assign rx_line = use_loop ? tx_ser : drv;

  duplex_uart u_dut (
    .tx_clk(clk), .rx_clk(clk), .rst(rst),
    .len_sel(len_sel), .par_off(par_off), .even_par(even_par), .two_stop(two_stop),
    .tx_data(tx_data), .tx_load(tx_load),
    .tx_buf_empty(tx_buf_empty), .tx_reg_empty(tx_reg_empty), .tx_ser(tx_ser),
    .rx_ser(rx_line), .rx_flag_clr(rx_flag_clr),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk) rx_flag_clr = 1'b1;
    @(negedge clk) rx_flag_clr = 1'b0;
  endtask

  // transmit one character through loopback and check the line and the receiver
  task automatic send_tx(input logic [1:0] ls, input int pm, input logic ts,
                         input logic [7:0] d, input bit b2b, input logic [7:0] d2);
    int len, halves, nbit, tot;
    logic [9:0] b;
    logic [7:0] m;
    bit pon, ev;
    len    = int'(ls) + 5;
    m      = 8'((1 << len) - 1);
    pon    = (pm != 0);
    ev     = (pm == 1);
    halves = !ts ? 2 : (len == 5 ? 3 : 4);
    b      = '0;
    for (int i = 0; i < len; i++) b[1 + i] = d[i];
    if (pon) b[1 + len] = ev ? ^(d & m) : ~^(d & m);
    nbit = 1 + len + int'(pon);
    tot  = nbit * 16 + halves * 8;
    use_loop = 1'b1;
    @(negedge clk);
    len_sel = ls; par_off = !pon; even_par = ev; two_stop = ts;
    tx_data = d; tx_load = 1'b1;
    @(negedge clk);
    chk("R4 buffer flag after strobe edge", tx_buf_empty, 0);
    @(negedge clk);
    chk("R4 buffer flag after handoff", tx_buf_empty, 1);
    chk("R4 shifter busy after handoff", tx_reg_empty, 0);
    chk("R5 start bit low", tx_ser, 0);
    tx_load = 1'b0;
    for (int n = 1; n <= tot; n++) begin
      @(negedge clk);
      if (b2b && n == 20) begin
        tx_data = d2; tx_load = 1'b1;
      end
      if (b2b && n == 21) begin
        tx_load = 1'b0;
        chk("R6 buffer filled during frame", tx_buf_empty, 0);
      end
      if (n % 16 == 8 && n / 16 < nbit) begin
        if (n / 16 == 0)          chk("R5 start bit centre", tx_ser, 0);
        else if (n / 16 <= len)   chk("R1 data bit", tx_ser, b[n / 16]);
        else                      chk("R2 parity bit", tx_ser, b[n / 16]);
      end
      if (n / 16 == nbit && n % 16 == 8) chk("R3 stop bit high", tx_ser, 1);
      if (n == tot - 1) chk("R3 busy through last stop tick", tx_reg_empty, 0);
      if (n == tot) begin
        if (b2b) begin
          chk("R6 next start on frame end", tx_ser, 0);
          chk("R6 shifter stays busy", tx_reg_empty, 0);
        end else begin
          chk("R3 idle after stop length", tx_reg_empty, 1);
        end
      end
    end
    chk("R8 received flag", rx_ready, 1);
    chk("R8 right-justified data", rx_data, d & m);
    chk("R10 no framing error", rx_frame_err, 0);
    chk("R10 no parity error", rx_parity_err, 0);
    chk("R9 no overrun", rx_overrun, 0);
    clear_flag();
    chk("R12 flag reset clears ready", rx_ready, 0);
    if (b2b) begin
      repeat (tot) @(negedge clk);
      chk("R6 second character received", rx_data, d2 & m);
      chk("R6 second ready", rx_ready, 1);
      chk("R6 idle after second frame", tx_reg_empty, 1);
      clear_flag();
    end
  endtask

  task automatic drive_rx(input logic [11:0] bits, input int nb, input int clr_at);
    use_loop = 1'b0;
    for (int k = 0; k < nb * 16 + 40; k++) begin
      @(negedge clk);
      drv         = (k < nb * 16) ? bits[k / 16] : 1'b1;
      rx_flag_clr = (k == clr_at);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 reset line", tx_ser, 1);
    chk("R7 reset buffer empty", tx_buf_empty, 1);
    chk("R7 reset shifter empty", tx_reg_empty, 1);
    chk("R7 reset ready", rx_ready, 0);
    chk("R7 reset overrun", rx_overrun, 0);
    chk("R7 reset framing", rx_frame_err, 0);
    chk("R7 reset parity", rx_parity_err, 0);
    chk("R7 reset data", rx_data, 0);

    // format sweep: all lengths, parity modes and stop selections
    for (int ls = 0; ls < 4; ls++)
      for (int pm = 0; pm < 3; pm++)
        for (int ts = 0; ts < 2; ts++) begin
          logic [7:0] d1;
          d1 = 8'(ls * 73 + pm * 29 + ts * 151 + 13);
          send_tx(2'(ls), pm, 1'(ts), d1, 1'b0, 8'h00);
          send_tx(2'(ls), pm, 1'(ts), ~d1, 1'b0, 8'h00);
        end

    send_tx(2'b11, 1, 1'b0, 8'hC3, 1'b1, 8'h3C);
    send_tx(2'b00, 2, 1'b1, 8'h16, 1'b1, 8'h09);

    // strobe held high: one frame only
    @(negedge clk);
    len_sel = 2'b11; par_off = 1'b1; two_stop = 1'b0; use_loop = 1'b1;
    tx_data = 8'h81; tx_load = 1'b1;
    repeat (400) @(negedge clk);
    chk("R4 held strobe sends once, shifter idle", tx_reg_empty, 1);
    chk("R4 held strobe sends once, buffer empty", tx_buf_empty, 1);
    chk("R4 held strobe data", rx_data, 8'h81);
    tx_load = 1'b0;
    clear_flag();

    // receiver driven directly: 8 bits, even parity, one stop
    len_sel = 2'b11; par_off = 1'b0; even_par = 1'b1; two_stop = 1'b0;
    drive_rx({1'b0, 1'b1, 1'b1, 8'h03, 1'b0}, 11, -1);
    chk("R10 parity error flagged", rx_parity_err, 1);
    chk("R10 parity case no framing", rx_frame_err, 0);
    chk("R8 data with bad parity", rx_data, 8'h03);
    clear_flag();
    drive_rx({1'b0, 1'b1, 1'b1, 8'h07, 1'b0}, 11, -1);
    chk("R10 parity error cleared on good frame", rx_parity_err, 0);
    chk("R9 first frame no overrun", rx_overrun, 0);
    drive_rx({1'b0, 1'b1, 1'b1, 8'h10, 1'b0}, 11, -1);
    chk("R9 overrun when ready still set", rx_overrun, 1);
    chk("R9 overrun data replaced", rx_data, 8'h10);
    // flag reset on the transfer edge: 10 + 16*(8 data + parity + stop)
    drive_rx({1'b0, 1'b1, 1'b1, 8'h20, 1'b0}, 11, 10 + 16 * 10);
    chk("R12 transfer wins over flag reset", rx_ready, 1);
    chk("R12 no overrun on coinciding reset", rx_overrun, 0);
    chk("R12 data on coinciding reset", rx_data, 8'h20);
    clear_flag();

    // framing error: 7 bits, no parity, stop bit low
    len_sel = 2'b10; par_off = 1'b1;
    drive_rx({3'b000, 1'b0, 7'h55, 1'b0}, 9, -1);
    chk("R10 framing error flagged", rx_frame_err, 1);
    chk("R10 no parity error when disabled", rx_parity_err, 0);
    chk("R8 seven-bit data zero-filled", rx_data, 8'h55);
    clear_flag();
    repeat (40) @(negedge clk);
    chk("R11 trailing low stop not taken as start", rx_ready, 0);

    // glitch shorter than half a bit
    len_sel = 2'b11;
    use_loop = 1'b0;
    repeat (5) @(negedge clk) drv = 1'b0;
    @(negedge clk) drv = 1'b1;
    repeat (200) @(negedge clk);
    chk("R11 glitch discarded", rx_ready, 0);
    drive_rx({2'b00, 1'b1, 8'hE4, 1'b0}, 10, -1);
    chk("R11 frame after glitch ready", rx_ready, 1);
    chk("R11 frame after glitch data", rx_data, 8'hE4);
    chk("R10 frame after glitch framing", rx_frame_err, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule